// File: doc/BRIEF.md
# System Clock Rate Selector with Peripheral Prescaler

This block picks the rate of the CPU system clock and of the base peripheral clock f2. It chooses from a fast main clock and a slow sub clock, under three control bits. Everything runs on the main clock. Each derived clock is a one-cycle enable strobe, never a gated clock. The sub clock comes in as a raw level. Inside the block it is synchronized and edge-detected, so that each of its rising edges becomes a single-cycle step.

Software writes the three control bits together through a write strobe. The block applies a new setting only at the end of the f2 period that is running, so no enable pulse is ever cut short or doubled. A binary chain divides f2 by powers of two, from f2/2 up to f2/512. A separate counter gives the sub clock divided by 32. The sub-oscillator enable output shows the sub-select bit as written.

Top module: `sysclk_prescaler`

## Requirements
- R1: After reset all three control bits are 0 and `sub_osc_en` is 0. `sys_en` is high on every main cycle, and `f2_en` pulses on every second main cycle.
- R2: With `wr_data[2]`=0 (sub clock unused) and `wr_data[1]`=0, `sys_en` is high every main cycle. `f2_en` pulses every 2 main cycles when `wr_data[0]`=0, and every main cycle when `wr_data[0]`=1.
- R3: With sub unused and `wr_data[1]`=1, `sys_en` pulses every 8 main cycles. `f2_en` pulses every 16 main cycles when `wr_data[0]`=0, and every 8 when `wr_data[0]`=1.
- R4: With `wr_data[2]`=1 and `wr_data[1]`=0, the rates match R2, so the division bit `wr_data[0]` still chooses between main/2 and main/1 for f2.
- R5: With `wr_data[2]`=1 and `wr_data[1]`=1, `sys_en` pulses once per sub-clock rising edge and `f2_en` on every second one. `wr_data[0]` has no effect in this setting.
- R6: One cycle after a write, `sub_osc_en` equals the written `wr_data[2]`.
- R7: A rising edge of `sub_clk_in` becomes a one-cycle internal step. That step is visible on `sys_en` in sub mode on the second falling clock edge after the input changes, and on no later edge.
- R8: A new setting takes effect at the first `f2_en` pulse after the write. That pulse still ends a full period of the old setting, and from it on, the counters run the new ratios.
- R9: `pdiv_en[k]` pulses together with every 2^(k+1)-th `f2_en` pulse, so bit 8 gives f2/512.
- R10: `fc32_en` pulses on every 32nd sub-clock step, whatever the control bits say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control bits |
| wr_data | input | 3 | [2] sub select, [1] slow system clock, [0] f2 division bit |
| sub_clk_in | input | 1 | Raw sub-clock level, asynchronous |
| sys_en | output | 1 | System clock enable strobe |
| f2_en | output | 1 | Peripheral clock f2 enable strobe |
| pdiv_en | output | 9 | Strobes at f2/2 through f2/512 |
| fc32_en | output | 1 | Sub clock divided by 32 strobe |
| sub_osc_en | output | 1 | Sub oscillator enable |

## Verification
A wrong active setting or a skewed rate counter shows at once as a changed gap between `f2_en` or `sys_en` pulses. A bench model that follows the same switch-at-boundary rule catches it on the first misplaced strobe, no more than 16 main cycles or two sub periods later. A prescaler counter that is off by one shows in `pdiv_en` within one f2/512 period. A synchronizer latency fault shifts the sub-mode `sys_en` pulse by a whole cycle, and the check on the second falling edge sees that. The model is compared with every output on every cycle, across all eight settings and the switches between them.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

    // Rate counter width: the largest f2 ratio is 16 source steps
    localparam int CNT_W = 4;

    // Field order matches wr_data bit positions
    typedef struct packed {
        logic sub_sel;   // wr_data[2]
        logic sys_slow;  // wr_data[1]
        logic f2_fast;   // wr_data[0]
    } clk_cfg_t;

    typedef struct packed {
        logic             from_sub;
        logic [CNT_W-1:0] sys_mask;
        logic [CNT_W-1:0] f2_mask;
    } ratio_t;

    function automatic logic [CNT_W-1:0] mask_of(input int unsigned lg);
        return CNT_W'((1 << lg) - 1);
    endfunction

    // Control bits to divide masks, in source steps
    function automatic ratio_t decode_cfg(input clk_cfg_t c);
        ratio_t r;
        r.from_sub = c.sub_sel & c.sys_slow;
        if (r.from_sub) begin
            r.sys_mask = mask_of(0);
            r.f2_mask  = mask_of(1);
        end else if (c.sys_slow) begin
            r.sys_mask = mask_of(3);
            r.f2_mask  = c.f2_fast ? mask_of(3) : mask_of(4);
        end else begin
            r.sys_mask = mask_of(0);
            r.f2_mask  = c.f2_fast ? mask_of(0) : mask_of(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/clkpre_sync_edge.sv
module clkpre_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic pulse
);
    // sh[STAGES-1:0] form the synchronizer; sh[STAGES] holds the previous level
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], async_in};
    end

    assign pulse = sh[STAGES-1] & ~sh[STAGES];

    // R7: an edge step never lasts longer than one cycle
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/clkpre_rate.sv
module clkpre_rate
    import clkpre_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t pend_cfg,
    input  logic     sub_pulse,
    output logic     sys_en,
    output logic     f2_en
);
    clk_cfg_t         act_cfg;
    ratio_t           rt;
    logic [CNT_W-1:0] cnt;
    logic             step;

    always_comb begin
        rt     = decode_cfg(act_cfg);
        step   = rt.from_sub ? sub_pulse : 1'b1;
        f2_en  = step && (cnt == rt.f2_mask);
        sys_en = step && ((cnt & rt.sys_mask) == rt.sys_mask);
    end

    // The setting is swapped only at an f2 boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg <= '0;
            cnt     <= '0;
        end else if (f2_en) begin
            act_cfg <= pend_cfg;
            cnt     <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the active setting holds between f2 boundaries
    a_r8_hold_cfg: assert property (@(posedge clk) disable iff (rst)
        !f2_en |=> $stable(act_cfg));

    // R3: every f2 boundary is also a system clock boundary
    a_r3_f2_on_sys: assert property (@(posedge clk) disable iff (rst)
        f2_en |-> sys_en);

endmodule

// File: rtl/clkpre_chain.sv
module clkpre_chain #(
    parameter int STAGES = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [STAGES-1:0] en
);
    logic [STAGES-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_tap
        assign en[k] = tick & (&cnt[k:0]);
    end

    // R9: the slowest tap is never high two cycles in a row
    a_r9_top_tap: assert property (@(posedge clk) disable iff (rst)
        en[STAGES-1] |=> !en[STAGES-1]);

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
    import clkpre_pkg::*;
#(
    parameter int PDIV_STAGES = 9,
    parameter int SYNC_STAGES = 2,
    parameter int FC_LOG2     = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [2:0]             wr_data,
    input  logic                   sub_clk_in,
    output logic                   sys_en,
    output logic                   f2_en,
    output logic [PDIV_STAGES-1:0] pdiv_en,
    output logic                   fc32_en,
    output logic                   sub_osc_en
);
    clk_cfg_t           cfg_q;
    logic               sub_pulse;
    logic [FC_LOG2-1:0] fc_cnt;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= clk_cfg_t'(wr_data);
    end

    assign sub_osc_en = cfg_q.sub_sel;

    clkpre_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sub_clk_in),
        .pulse    (sub_pulse)
    );

    clkpre_rate u_rate (
        .clk       (clk),
        .rst       (rst),
        .pend_cfg  (cfg_q),
        .sub_pulse (sub_pulse),
        .sys_en    (sys_en),
        .f2_en     (f2_en)
    );

    clkpre_chain #(.STAGES(PDIV_STAGES)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .tick (f2_en),
        .en   (pdiv_en)
    );

    always_ff @(posedge clk) begin
        if (rst)            fc_cnt <= '0;
        else if (sub_pulse) fc_cnt <= fc_cnt + 1'b1;
    end

    assign fc32_en = sub_pulse & (&fc_cnt);

    // R6: the oscillator enable shows the last written sub-select bit
    a_r6_osc_follow: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sub_osc_en == $past(wr_data[2]));

    // R9: prescaler strobes only appear together with f2
    a_r9_pdiv_on_f2: assert property (@(posedge clk) disable iff (rst)
        (|pdiv_en) |-> f2_en);

    // R10: the sub/32 strobe is a single cycle
    a_r10_fc_single: assert property (@(posedge clk) disable iff (rst)
        fc32_en |=> !fc32_en);

endmodule

// File: tb/sysclk_prescaler_test.sv
module sysclk_prescaler_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'd0;
    logic       sub_clk_in = 1'b0;
    logic       sys_en, f2_en, fc32_en, sub_osc_en;
    logic [8:0] pdiv_en;

    int  vecs = 0;
    int  miss = 0;
    bit  chk_on = 1'b0;
    bit  sub_run = 1'b1;

    always #10 clk = ~clk;

    sysclk_prescaler uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .sub_clk_in(sub_clk_in), .sys_en(sys_en), .f2_en(f2_en),
        .pdiv_en(pdiv_en), .fc32_en(fc32_en), .sub_osc_en(sub_osc_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Ratios taken from the requirement table
    function automatic bit m_sub(input int c);
        return (c & 6) == 6;
    endfunction
    function automatic int m_f2r(input int c);
        if (m_sub(c)) return 2;
        if (c & 2)    return (c & 1) ? 8 : 16;
        return (c & 1) ? 1 : 2;
    endfunction
    function automatic int m_sysr(input int c);
        if (m_sub(c)) return 1;
        return (c & 2) ? 8 : 1;
    endfunction

    // Behavioural reference model
    int m_reg = 0, m_act = 0, m_cnt = 0, m_pcnt = 0, m_fcnt = 0;
    bit s1 = 0, s2 = 0, s3 = 0;

    always @(posedge clk) begin
        bit p, ev;
        if (rst) begin
            m_reg = 0; m_act = 0; m_cnt = 0; m_pcnt = 0; m_fcnt = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            p  = s2 && !s3;
            ev = m_sub(m_act) ? p : 1'b1;
            if (ev) begin
                if (m_cnt == m_f2r(m_act) - 1) begin
                    m_cnt  = 0;
                    m_act  = m_reg;
                    m_pcnt = (m_pcnt + 1) % 512;
                end else begin
                    m_cnt++;
                end
            end
            if (p) m_fcnt = (m_fcnt + 1) % 32;
            if (wr_en) m_reg = int'(wr_data);
            s3 = s2; s2 = s1; s1 = sub_clk_in;
        end
    end

    always @(negedge clk) begin
        bit p, ev, e_f2, e_sys;
        int e_pd;
        if (chk_on) begin
            p     = s2 && !s3;
            ev    = m_sub(m_act) ? p : 1'b1;
            e_f2  = ev && (m_cnt == m_f2r(m_act) - 1);
            e_sys = ev && ((m_cnt % m_sysr(m_act)) == m_sysr(m_act) - 1);
            e_pd  = 0;
            for (int k = 0; k < 9; k++)
                if (e_f2 && ((m_pcnt % (2 << k)) == (2 << k) - 1)) e_pd |= (1 << k);
            chk("R8 f2_en cycle", int'(f2_en), int'(e_f2));
            chk("R8 sys_en cycle", int'(sys_en), int'(e_sys));
            chk("R9 pdiv_en cycle", int'(pdiv_en), e_pd);
            chk("R10 fc32_en cycle", int'(fc32_en), int'(p && m_fcnt == 31));
            chk("R6 sub_osc_en cycle", int'(sub_osc_en), (m_reg >> 2) & 1);
        end
    end

    // Free-running sub clock: period of 10 main cycles
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            if (sub_run) sub_clk_in = ~sub_clk_in;
        end
    end

    function automatic logic sig(input int s);
        case (s)
            0:       return sys_en;
            1:       return f2_en;
            2:       return pdiv_en[8];
            default: return fc32_en;
        endcase
    endfunction

    task automatic gap_of(input int s, output int g);
        int n = 0;
        @(negedge clk);
        while (!sig(s) && n < 3000) begin @(negedge clk); n++; end
        g = 0;
        do begin @(negedge clk); g++; end while (!sig(s) && g < 3000);
    endtask

    task automatic write_cfg(input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 3'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int g;
        string tag;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        // R1: reset state
        chk("R1 sys_en after reset", int'(sys_en), 1);
        chk("R1 sub_osc_en after reset", int'(sub_osc_en), 0);
        gap_of(1, g); chk("R1 f2 gap", g, 2);
        gap_of(0, g); chk("R1 sys gap", g, 1);

        // All eight settings
        for (int c = 0; c < 8; c++) begin
            if (m_sub(c))   tag = "R5";
            else if (c & 2) tag = "R3";
            else if (c & 4) tag = "R4";
            else            tag = "R2";
            write_cfg(c);
            chk("R6 sub_osc_en", int'(sub_osc_en), (c >> 2) & 1);
            repeat (60) @(negedge clk);
            gap_of(1, g);
            chk({tag, " f2 gap"}, g, m_sub(c) ? 20 : m_f2r(c));
            gap_of(0, g);
            chk({tag, " sys gap"}, g, m_sub(c) ? 10 : m_sysr(c));
        end

        // R7: sync latency in sub mode
        sub_run = 1'b0;
        @(negedge clk); sub_clk_in = 1'b0;
        write_cfg(6);
        repeat (40) @(negedge clk);
        sub_clk_in = 1'b1;
        @(negedge clk); chk("R7 no step after 1 edge", int'(sys_en), 0);
        @(negedge clk); chk("R7 step after 2 edges", int'(sys_en), 1);
        @(negedge clk); chk("R7 step is one cycle", int'(sys_en), 0);
        sub_run = 1'b1;

        // R8: switch from f2/16 to f2/8 right at a boundary
        write_cfg(2);
        repeat (40) @(negedge clk);
        while (!f2_en) @(negedge clk);
        wr_en = 1'b1; wr_data = 3'd3;
        @(negedge clk); wr_en = 1'b0;
        g = 1;
        while (!f2_en && g < 100) begin @(negedge clk); g++; end
        chk("R8 old period completes", g, 16);
        gap_of(1, g);
        chk("R8 new period", g, 8);

        // R9 and R10 with f2 every main cycle
        write_cfg(1);
        repeat (20) @(negedge clk);
        gap_of(2, g); chk("R9 f2/512 gap", g, 512);
        gap_of(3, g); chk("R10 fc32 gap", g, 320);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule